// File: doc/BRIEF.md
# Inversion-Controlled Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a processor datapath. It takes two operands of parameterised width and a 4-bit control word, and returns a result and a flag that marks an all-zero result. The default width is 32 bits. A 4-bit build is also supported.

There are no separate subtract or NOR units. Each operand can be inverted on its way in. One of four bit-sliced paths then produces the result: bitwise AND, bitwise OR, a ripple adder, or a signed less-than. Subtract is the adder with operand B inverted and the carry-in raised. NOR is the AND path with both operands inverted. Every control code gives a defined result.

The control decoder of the datapath drives the control word. The zero flag feeds the branch-equal decision.

Top module: `inv_alu`

## Requirements
- R1: The control word ctrl_i splits into three fields. Bit 3 inverts operand A. Bit 2 inverts operand B. Bits 1:0 select the path: 00 AND, 01 OR, 10 add, 11 set-less-than. Every path sees the operands after inversion.
- R2: ctrl_i = 0000 gives result_o = a_i & b_i.
- R3: ctrl_i = 0001 gives result_o = a_i | b_i.
- R4: ctrl_i = 0010 gives result_o = a_i + b_i modulo 2^WIDTH.
- R5: ctrl_i = 0110 gives result_o = a_i - b_i modulo 2^WIDTH.
- R6: ctrl_i = 0111 gives result_o = 1 when a_i < b_i as signed two's-complement values, and 0 otherwise. Bits above bit 0 are always 0. The answer stays correct when the internal subtraction overflows.
- R7: ctrl_i = 1100 gives result_o = ~(a_i | b_i).
- R8: zero_o is 1 exactly when every bit of result_o is 0. This holds for every control code.
- R9: Control codes not listed above give the output of the path selected by bits 1:0, with the inversions applied. The adder carry-in always equals bit 2. On the less-than path, result bit 0 is the sign of the exact (non-wrapping) sum of the inverted operands plus that carry-in.
- R10: With WIDTH = 4, R1 to R9 hold for every combination of operands and control code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| ctrl_i | input | 4 | Control word {invert A, invert B, path select[1:0]} |
| result_o | output | WIDTH | Result of the selected path |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The hardest case to reach is a less-than compare where the subtraction overflows. The raw sign bit of the difference then gives the wrong answer, and only the overflow correction saves it. This needs operands at opposite ends of the signed range, such as the most negative value against a small positive one, or the most positive value against the most negative one. The vector table lists these pairs by name. An exhaustive sweep of the 4-bit build covers every overflow pattern under all sixteen control codes, including the less-than path without B inverted.

// File: rtl/inv_alu_pkg.sv
package inv_alu_pkg;

  localparam int unsigned CTRL_W = 4;

  typedef enum logic [1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_ADD = 2'b10,
    FN_SLT = 2'b11
  } fn_sel_e;

  // bit order is decoded by the control unit: {inv_a, inv_b, fn}
  typedef struct packed {
    logic    inv_a;
    logic    inv_b;
    fn_sel_e fn;
  } alu_ctrl_t;

endpackage

// File: rtl/inv_alu_slice.sv
module inv_alu_slice (
  input  logic a_i,
  input  logic b_i,
  input  logic inv_a_i,
  input  logic inv_b_i,
  input  logic cin_i,
  output logic and_o,
  output logic or_o,
  output logic sum_o,
  output logic cout_o
);

  logic a_m;
  logic b_m;

  assign a_m    = a_i ^ inv_a_i;
  assign b_m    = b_i ^ inv_b_i;
  assign and_o  = a_m & b_m;
  assign or_o   = a_m | b_m;
  assign sum_o  = a_m ^ b_m ^ cin_i;
  assign cout_o = (a_m & b_m) | (cin_i & (a_m ^ b_m));

endmodule

// File: rtl/inv_alu_chain.sv
module inv_alu_chain #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_o,
  output logic             cout_o
);

  logic [WIDTH:0] carry;

  // carry-in tied to inv_b: inverted B plus one is the two's complement
  assign carry[0] = inv_b_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    inv_alu_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .inv_a_i (inv_a_i),
      .inv_b_i (inv_b_i),
      .cin_i   (carry[i]),
      .and_o   (and_o[i]),
      .or_o    (or_o[i]),
      .sum_o   (sum_o[i]),
      .cout_o  (carry[i+1])
    );
  end

  assign c_msb_o = carry[WIDTH-1];
  assign cout_o  = carry[WIDTH];

endmodule

// File: rtl/inv_alu_zero.sv
module inv_alu_zero #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);

  assign zero_o = ~(|vec_i);

endmodule

// File: rtl/inv_alu.sv
module inv_alu
  import inv_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              zero_o
);

  localparam int unsigned MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic [WIDTH-1:0] sum_v;
  logic             c_msb;
  logic             c_out;
  logic             ovf;
  logic             slt_bit;

  assign ctrl = alu_ctrl_t'(ctrl_i);

  inv_alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i     (a_i),
    .b_i     (b_i),
    .inv_a_i (ctrl.inv_a),
    .inv_b_i (ctrl.inv_b),
    .and_o   (and_v),
    .or_o    (or_v),
    .sum_o   (sum_v),
    .c_msb_o (c_msb),
    .cout_o  (c_out)
  );

  // sign of the exact sum: raw sign flipped on signed overflow
  assign ovf     = c_msb ^ c_out;
  assign slt_bit = sum_v[MSB] ^ ovf;

  always_comb begin
    unique case (ctrl.fn)
      FN_AND:  result_o = and_v;
      FN_OR:   result_o = or_v;
      FN_ADD:  result_o = sum_v;
      FN_SLT:  result_o = {{(WIDTH-1){1'b0}}, slt_bit};
      default: result_o = and_v;
    endcase
  end

  inv_alu_zero #(.WIDTH(WIDTH)) u_zero (
    .vec_i  (result_o),
    .zero_o (zero_o)
  );

  always_comb begin
    if (ctrl_i == 4'b0000) begin
      AST_AND_PATH: assert (result_o == (a_i & b_i)) else $error("and path"); // R2
    end
    if (ctrl_i == 4'b0110) begin
      AST_SUB_PATH: assert (result_o == WIDTH'(a_i - b_i)) else $error("sub path"); // R5
    end
    if (ctrl_i == 4'b1100) begin
      AST_NOR_PATH: assert (result_o == ~(a_i | b_i)) else $error("nor path"); // R7
    end
    if (ctrl_i[1:0] == 2'b11) begin
      AST_SLT_UPPER: assert (result_o[MSB:1] == '0) else $error("slt upper bits"); // R6
    end
    if (ctrl_i == 4'b0111) begin
      AST_SLT_SIGNED: assert (result_o[0] == ($signed(a_i) < $signed(b_i))) else $error("slt signed"); // R6
    end
    AST_ZERO_FLAG: assert (zero_o == (result_o == '0)) else $error("zero flag"); // R8
  end

endmodule

// File: tb/inv_alu_bench.sv
module inv_alu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int NVEC       = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [3:0]   ctrl;
  logic         zero;
  logic [3:0]   a4, b4, res4;
  logic [3:0]   ctrl4;
  logic         zero4;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  inv_alu #(.WIDTH(W)) u_inv_alu (
    .a_i(a), .b_i(b), .ctrl_i(ctrl), .result_o(res), .zero_o(zero)
  );

  inv_alu #(.WIDTH(4)) u_inv_alu_w4 (
    .a_i(a4), .b_i(b4), .ctrl_i(ctrl4), .result_o(res4), .zero_o(zero4)
  );

  // {ctrl, a, b, expected}
  localparam logic [99:0] VEC [NVEC] = '{
    {4'b0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000},
    {4'b0001, 32'hF0F0F0F0, 32'h0000FFFF, 32'hF0F0FFFF},
    {4'b0010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000},
    {4'b0010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    {4'b0110, 32'h00000005, 32'h00000007, 32'hFFFFFFFE},
    {4'b0110, 32'h12345678, 32'h12345678, 32'h00000000},
    {4'b0111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001},
    {4'b0111, 32'h00000001, 32'hFFFFFFFF, 32'h00000000},
    {4'b0111, 32'h80000000, 32'h00000001, 32'h00000001},
    {4'b0111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000},
    {4'b0111, 32'h00000003, 32'h00000003, 32'h00000000},
    {4'b1100, 32'h0F0F0000, 32'h00F000F0, 32'hF000FF0F},
    {4'b1000, 32'h0000FFFF, 32'h00FF00FF, 32'h00FF0000},
    {4'b0101, 32'h00000000, 32'hFFFFFFFE, 32'h00000001},
    {4'b1110, 32'h00000001, 32'h00000002, 32'hFFFFFFFC},
    {4'b0011, 32'h80000000, 32'h80000000, 32'h00000001}
  };

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'b0000: return "R2";
      4'b0001: return "R3";
      4'b0010: return "R4";
      4'b0110: return "R5";
      4'b0111: return "R6";
      4'b1100: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic longint unsigned model(int w, longint unsigned x, longint unsigned y,
                                            logic [3:0] c);
    longint unsigned mask = (64'd1 << w) - 1;
    longint unsigned xm = (c[3] ? ~x : x) & mask;
    longint unsigned ym = (c[2] ? ~y : y) & mask;
    longint sx = longint'(xm);
    longint sy = longint'(ym);
    longint s;
    if (((xm >> (w - 1)) & 1) != 0) sx = sx - (longint'(1) << w);
    if (((ym >> (w - 1)) & 1) != 0) sy = sy - (longint'(1) << w);
    s = sx + sy + longint'(c[2]);
    case (c[1:0])
      2'b00:   return xm & ym;
      2'b01:   return xm | ym;
      2'b10:   return longint'(s) & mask;
      default: return (s < 0) ? 64'd1 : 64'd0;
    endcase
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply32(logic [3:0] c, logic [W-1:0] x, logic [W-1:0] y);
    @(posedge clk);
    #1;
    ctrl = c; a = x; b = y;
    @(negedge clk);
  endtask

  initial begin
    a = '0; b = '0; ctrl = '0; a4 = '0; b4 = '0; ctrl4 = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8: idle inputs give zero result and raised flag
    check("R8 idle result", res, 0);
    check("R8 idle zero", zero, 1);

    // table walk: R1..R9 at named points, incl. overflowing compares for R6
    for (int i = 0; i < NVEC; i++) begin
      apply32(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32]);
      check(tag_of(VEC[i][99:96]), res, VEC[i][31:0]);
      check("R8 zero flag", zero, (VEC[i][31:0] == 0));
    end

    // R1 R9: every code against the model, pseudo-random 32-bit operands
    begin
      logic [31:0] lfsr = 32'hACE1_2357;
      for (int k = 0; k < 200; k++) begin
        logic [31:0] x, y;
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        x = lfsr;
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        y = (k % 4 == 0) ? x : lfsr;
        for (int c = 0; c < 16; c++) begin
          apply32(4'(c), x, y);
          check({"R1 ", tag_of(4'(c))}, res, model(W, x, y, 4'(c)));
          check("R8 zero flag", zero, (res == 0));
        end
      end
    end

    // R10: exhaustive 4-bit build
    for (int c = 0; c < 16; c++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          @(posedge clk);
          #1;
          ctrl4 = 4'(c); a4 = 4'(x); b4 = 4'(y);
          @(negedge clk);
          check("R10 result", res4, model(4, longint'(x), longint'(y), 4'(c)));
          check("R10 zero", zero4, (model(4, longint'(x), longint'(y), 4'(c)) == 0));
        end
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule